// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational execute datapath of a small 32-bit integer core. It receives the two register operands (`rs_i`, `rt_i`), the 16-bit immediate field, the 5-bit shift-amount field and a 5-bit operation code. It returns a 32-bit result and a vector of six branch-condition flags in the same cycle. No clock, reset or state is involved.

The operation code selects the result. Each immediate form applies its own extension: arithmetic and compare immediates are sign-extended, and logic immediates are zero-extended. A shift takes its amount from either the instruction field or the low bits of `rs_i`.

Load and store addresses are formed with the add-immediate code (rs plus the sign-extended offset). The branch flags are always valid, whatever the operation code, and the next-PC logic outside this block picks the one it needs.

Top module: `xu_exec`

## Requirements
- R1: Codes 0 (add), 1 (subtract) and 14 (add sign-extended immediate, also used for load/store addresses) return rs+rt, rs-rt and rs+sext(imm) modulo 2^32, with no overflow indication.
- R2: Codes 2 (signed less-than, register) and 15 (signed less-than, sign-extended immediate) return 1 when rs is below the second operand as two's-complement values and 0 otherwise, in bit 0, with bits [31:1] zero.
- R3: Codes 3 (unsigned less-than, register) and 16 (unsigned less-than, sign-extended immediate) compare as unsigned numbers. The second operand of code 16 is sign-extended before the compare. The result is 1 or 0 in bit 0, with bits [31:1] zero.
- R4: Codes 4, 5, 6 and 7 return rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt), bit by bit.
- R5: Codes 17, 18 and 19 return rs AND, OR and XOR the zero-extended immediate.
- R6: Code 20 returns the immediate in bits [31:16] and zeros in bits [15:0].
- R7: Code 8 shifts rt left by `shamt_i`, filling the vacated bits with zeros.
- R8: Codes 11 (left), 12 (logical right) and 13 (arithmetic right) shift rt by rs[4:0]. Bits [31:5] of rs have no effect.
- R9: Codes 9 (logical right by `shamt_i`) and 12 fill the vacated upper bits with zeros. Codes 10 (arithmetic right by `shamt_i`) and 13 fill them with rt bit 31.
- R10: `cond_o` bit 0 is rs==rt, bit 1 is rs!=rt, bit 2 is rs<=0, bit 3 is rs>0, bit 4 is rs<0 and bit 5 is rs>=0. The sign tests use rs bit 31 and all six bits are valid for every code.
- R11: Codes 21 to 31 return a result of zero.
- R12: Register-operand codes (0 to 13) ignore `imm_i`. Codes 0 to 7 and 11 to 20 ignore `shamt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand / shift source |
| imm_i | input | 16 | Instruction immediate field |
| shamt_i | input | 5 | Constant shift amount field |
| op_i | input | 5 | Operation code (see requirements) |
| result_o | output | 32 | Operation result |
| cond_o | output | 6 | Branch-condition flags |

## Verification
The bench sweeps every operation code over corner operands: zero, one, all ones, the most negative and most positive values, and mixed patterns. A compare that used the wrong signedness would return the wrong result on the 0x80000000 versus 0x7fffffff pairs. Applying the wrong extension to an immediate shows up with immediates whose bit 15 is set, because a zero-extended compare immediate or a sign-extended logic immediate changes the upper half of the result. Every shift amount from 0 to 31 is driven on each shift code, with rs carrying junk in bits [31:5] and `shamt_i` set to a different value. This exposes a shifter that reads the wrong amount source, lets the high bits of rs leak in, or fills with the wrong bit. The branch flags are checked on signed boundaries, where a flag taken from a magnitude compare instead of bit 31 would flip.

// File: rtl/xu_pkg.sv
package xu_pkg;

  typedef enum logic [4:0] {
    OP_ADDU  = 5'd0,  OP_SUBU  = 5'd1,  OP_SLT   = 5'd2,  OP_SLTU  = 5'd3,
    OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_NOR   = 5'd7,
    OP_SLL   = 5'd8,  OP_SRL   = 5'd9,  OP_SRA   = 5'd10, OP_SLLV  = 5'd11,
    OP_SRLV  = 5'd12, OP_SRAV  = 5'd13, OP_ADDIU = 5'd14, OP_SLTI  = 5'd15,
    OP_SLTIU = 5'd16, OP_ANDI  = 5'd17, OP_ORI   = 5'd18, OP_XORI  = 5'd19,
    OP_LUI   = 5'd20
  } xu_op_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ARITH, SEL_CMP, SEL_LOGIC, SEL_SHIFT, SEL_UPPER
  } res_sel_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} lg_fn_e;

  typedef struct packed {
    res_sel_e res_sel;
    logic     b_imm;
    logic     imm_sext;
    logic     sub;
    logic     cmp_signed;
    lg_fn_e   lg_fn;
    logic     sh_left;
    logic     sh_arith;
    logic     sh_var;
  } xu_ctrl_t;

  localparam int unsigned NCOND = 6;
  localparam int unsigned C_EQ  = 0;
  localparam int unsigned C_NE  = 1;
  localparam int unsigned C_LEZ = 2;
  localparam int unsigned C_GTZ = 3;
  localparam int unsigned C_LTZ = 4;
  localparam int unsigned C_GEZ = 5;

endpackage

// File: rtl/xu_decode.sv
module xu_decode
  import xu_pkg::*;
(
  input  logic [4:0] op_i,
  output xu_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o            = '0;
    ctrl_o.res_sel    = SEL_ZERO;
    ctrl_o.lg_fn      = LG_AND;
    unique case (op_i)
      OP_ADDU:  ctrl_o.res_sel = SEL_ARITH;
      OP_SUBU:  begin ctrl_o.res_sel = SEL_ARITH; ctrl_o.sub = 1'b1; end
      OP_SLT:   begin ctrl_o.res_sel = SEL_CMP; ctrl_o.sub = 1'b1; ctrl_o.cmp_signed = 1'b1; end
      OP_SLTU:  begin ctrl_o.res_sel = SEL_CMP; ctrl_o.sub = 1'b1; end
      OP_AND:   begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.lg_fn = LG_AND; end
      OP_OR:    begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.lg_fn = LG_OR;  end
      OP_XOR:   begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.lg_fn = LG_XOR; end
      OP_NOR:   begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.lg_fn = LG_NOR; end
      OP_SLL:   begin ctrl_o.res_sel = SEL_SHIFT; ctrl_o.sh_left = 1'b1; end
      OP_SRL:   ctrl_o.res_sel = SEL_SHIFT;
      OP_SRA:   begin ctrl_o.res_sel = SEL_SHIFT; ctrl_o.sh_arith = 1'b1; end
      OP_SLLV:  begin ctrl_o.res_sel = SEL_SHIFT; ctrl_o.sh_left = 1'b1; ctrl_o.sh_var = 1'b1; end
      OP_SRLV:  begin ctrl_o.res_sel = SEL_SHIFT; ctrl_o.sh_var = 1'b1; end
      OP_SRAV:  begin ctrl_o.res_sel = SEL_SHIFT; ctrl_o.sh_arith = 1'b1; ctrl_o.sh_var = 1'b1; end
      OP_ADDIU: begin ctrl_o.res_sel = SEL_ARITH; ctrl_o.b_imm = 1'b1; ctrl_o.imm_sext = 1'b1; end
      OP_SLTI:  begin
        ctrl_o.res_sel = SEL_CMP; ctrl_o.b_imm = 1'b1; ctrl_o.imm_sext = 1'b1;
        ctrl_o.sub = 1'b1; ctrl_o.cmp_signed = 1'b1;
      end
      OP_SLTIU: begin
        ctrl_o.res_sel = SEL_CMP; ctrl_o.b_imm = 1'b1; ctrl_o.imm_sext = 1'b1; ctrl_o.sub = 1'b1;
      end
      OP_ANDI:  begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.b_imm = 1'b1; ctrl_o.lg_fn = LG_AND; end
      OP_ORI:   begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.b_imm = 1'b1; ctrl_o.lg_fn = LG_OR;  end
      OP_XORI:  begin ctrl_o.res_sel = SEL_LOGIC; ctrl_o.b_imm = 1'b1; ctrl_o.lg_fn = LG_XOR; end
      OP_LUI:   ctrl_o.res_sel = SEL_UPPER;
      default:  ctrl_o.res_sel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/xu_addsub.sv
// One XLEN+1 adder serves add, subtract and both less-than forms.
module xu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            signed_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_o
);

  logic [XLEN:0] a_x, b_x, b_m, s_x;

  always_comb begin
    a_x   = {signed_i & a_i[XLEN-1], a_i};
    b_x   = {signed_i & b_i[XLEN-1], b_i};
    b_m   = sub_i ? ~b_x : b_x;
    s_x   = a_x + b_m + {{XLEN{1'b0}}, sub_i};
    sum_o = s_x[XLEN-1:0];
    lt_o  = s_x[XLEN];
  end

endmodule

// File: rtl/xu_logic.sv
module xu_logic
  import xu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  lg_fn_e          fn_i,
  output logic [XLEN-1:0] y_o
);

  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/xu_shift.sv
// Log-depth right barrel; left shifts reuse it through bit reversal.
module xu_shift #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] dout_o
);

  logic [XLEN-1:0] din_rev, src, last_rev;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign din_rev[i]  = din_i[XLEN-1-i];
    assign last_rev[i] = stg[SHW][XLEN-1-i];
  end

  assign src    = left_i ? din_rev : din_i;
  assign fill   = arith_i & ~left_i & din_i[XLEN-1];
  assign stg[0] = src;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][XLEN-1:STEP]} : stg[k];
  end

  assign dout_o = left_i ? last_rev : stg[SHW];

endmodule

// File: rtl/xu_branch.sv
module xu_branch
  import xu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  output logic [NCOND-1:0] cond_o
);

  logic eq, neg, zero;

  always_comb begin
    eq            = (rs_i == rt_i);
    neg           = rs_i[XLEN-1];
    zero          = (rs_i == '0);
    cond_o[C_EQ]  = eq;
    cond_o[C_NE]  = ~eq;
    cond_o[C_LEZ] = neg | zero;
    cond_o[C_GTZ] = ~(neg | zero);
    cond_o[C_LTZ] = neg;
    cond_o[C_GEZ] = ~neg;
  end

endmodule

// File: rtl/xu_exec.sv
module xu_exec
  import xu_pkg::*;
#(
  parameter  int unsigned XLEN = 32,
  parameter  int unsigned IMMW = 16,
  localparam int unsigned SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [IMMW-1:0]  imm_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [4:0]       op_i,
  output logic [XLEN-1:0]  result_o,
  output logic [NCOND-1:0] cond_o
);

  localparam int unsigned EXTW = XLEN - IMMW;

  xu_ctrl_t        ctrl;
  logic [XLEN-1:0] imm_ext, opb, sum, lg_y, sh_y;
  logic [SHW-1:0]  sh_amt;
  logic            lt;

  xu_decode i_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign imm_ext = {{EXTW{ctrl.imm_sext & imm_i[IMMW-1]}}, imm_i};
  assign opb     = ctrl.b_imm ? imm_ext : rt_i;
  assign sh_amt  = ctrl.sh_var ? rs_i[SHW-1:0] : shamt_i;

  xu_addsub #(.XLEN(XLEN)) i_addsub (
    .a_i      (rs_i),
    .b_i      (opb),
    .sub_i    (ctrl.sub),
    .signed_i (ctrl.cmp_signed),
    .sum_o    (sum),
    .lt_o     (lt)
  );

  xu_logic #(.XLEN(XLEN)) i_logic (
    .a_i  (rs_i),
    .b_i  (opb),
    .fn_i (ctrl.lg_fn),
    .y_o  (lg_y)
  );

  xu_shift #(.XLEN(XLEN), .SHW(SHW)) i_shift (
    .din_i   (rt_i),
    .amt_i   (sh_amt),
    .left_i  (ctrl.sh_left),
    .arith_i (ctrl.sh_arith),
    .dout_o  (sh_y)
  );

  xu_branch #(.XLEN(XLEN)) i_branch (
    .rs_i   (rs_i),
    .rt_i   (rt_i),
    .cond_o (cond_o)
  );

  always_comb begin
    unique case (ctrl.res_sel)
      SEL_ARITH: result_o = sum;
      SEL_CMP:   result_o = {{(XLEN-1){1'b0}}, lt};
      SEL_LOGIC: result_o = lg_y;
      SEL_SHIFT: result_o = sh_y;
      SEL_UPPER: result_o = {imm_i, {EXTW{1'b0}}};
      default:   result_o = '0;
    endcase
  end

endmodule

// File: rtl/xu_exec_chk.sv
module xu_exec_chk
  import xu_pkg::*;
#(
  parameter  int unsigned XLEN = 32,
  parameter  int unsigned IMMW = 16,
  localparam int unsigned SHW  = $clog2(XLEN)
) (
  input logic [XLEN-1:0]  rs_i,
  input logic [XLEN-1:0]  rt_i,
  input logic [IMMW-1:0]  imm_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [4:0]       op_i,
  input logic [XLEN-1:0]  result_o,
  input logic [NCOND-1:0] cond_o
);

  always_comb begin
    if (op_i == OP_ADDU)
      p_wrap_add_r1: assert (result_o - rt_i == rs_i);
    if (op_i == OP_SLT || op_i == OP_SLTI)
      p_cmp_bool_r2: assert (result_o[XLEN-1:1] == '0);
    if (op_i == OP_SLTU || op_i == OP_SLTIU)
      p_cmp_bool_r3: assert (result_o[XLEN-1:1] == '0);
    if (op_i == OP_ANDI)
      p_zext_and_r5: assert (result_o[XLEN-1:IMMW] == '0);
    if (op_i == OP_LUI)
      p_upper_imm_r6: assert (result_o[XLEN-1:XLEN-IMMW] == imm_i && result_o[XLEN-IMMW-1:0] == '0);
    if (op_i == OP_SLL && shamt_i == '0)
      p_sll_zero_r7: assert (result_o == rt_i);
    if (op_i == OP_SRA || op_i == OP_SRAV)
      p_sign_fill_r9: assert (result_o[XLEN-1] == rt_i[XLEN-1]);
    p_flag_pairs_r10: assert (cond_o[C_EQ] != cond_o[C_NE] && cond_o[C_LEZ] != cond_o[C_GTZ]
                              && cond_o[C_LTZ] != cond_o[C_GEZ] && cond_o[C_LTZ] == rs_i[XLEN-1]);
    if (op_i > OP_LUI)
      p_undef_zero_r11: assert (result_o == '0);
  end

endmodule

bind xu_exec xu_exec_chk #(.XLEN(XLEN), .IMMW(IMMW)) i_chk (.*);

// File: tb/test_xu_exec.sv
module test_xu_exec;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic [31:0] rs, rt, result;
  logic [15:0] imm;
  logic [4:0]  shamt, op;
  logic [5:0]  cond;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xu_exec i_xu_exec (
    .rs_i(rs), .rt_i(rt), .imm_i(imm), .shamt_i(shamt), .op_i(op),
    .result_o(result), .cond_o(cond)
  );

  function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [4:0] sh);
    logic [31:0] se, ze;
    se = 32'($signed(im));
    ze = {16'h0, im};
    case (o)
      0:  return a + b;
      1:  return a - b;
      2:  return {31'h0, $signed(a) < $signed(b)};
      3:  return {31'h0, a < b};
      4:  return a & b;
      5:  return a | b;
      6:  return a ^ b;
      7:  return ~(a | b);
      8:  return b << sh;
      9:  return b >> sh;
      10: return 32'($signed(b) >>> sh);
      11: return b << a[4:0];
      12: return b >> a[4:0];
      13: return 32'($signed(b) >>> a[4:0]);
      14: return a + se;
      15: return {31'h0, $signed(a) < $signed(se)};
      16: return {31'h0, a < se};
      17: return a & ze;
      18: return a | ze;
      19: return a ^ ze;
      20: return {im, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] o);
    case (o)
      0, 1, 14:       return "R1";
      2, 15:          return "R2";
      3, 16:          return "R3";
      4, 5, 6, 7:     return "R4";
      17, 18, 19:     return "R5";
      20:             return "R6";
      8:              return "R7";
      11:             return "R8";
      9, 10, 12, 13:  return "R9";
      default:        return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d rs=%h rt=%h imm=%h sh=%0d: got %h expected %h",
               req, op, rs, rt, imm, shamt, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh);
    op = o; rs = a; rt = b; imm = im; shamt = sh;
    #1;
  endtask

  function automatic logic [5:0] flags(input logic [31:0] a, input logic [31:0] b);
    logic [5:0] f;
    f[0] = (a == b);
    f[1] = (a != b);
    f[2] = ($signed(a) <= 0);
    f[3] = ($signed(a) > 0);
    f[4] = ($signed(a) < 0);
    f[5] = ($signed(a) >= 0);
    return f;
  endfunction

  logic [31:0] vals [12] = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000, 32'hffffffff,
                             32'hfffffffe, 32'h12345678, 32'h80000001, 32'h0000ffff,
                             32'hffff0000, 32'h7f0f00a5};
  logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
  logic [4:0]  shs  [6] = '{5'd0, 5'd1, 5'd15, 5'd31, 5'd7, 5'd16};

  initial begin : main
    // reset-like idle state: all inputs zero
    apply(5'd0, 32'h0, 32'h0, 16'h0, 5'd0);
    check("R1", result, 32'h0);
    check("R10", {26'h0, cond}, {26'h0, 6'b100101});

    // near-exhaustive sweep: every code against corner operands
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int k = 0; k < 6; k++) begin
            apply(5'(o), vals[i], vals[j], imms[k], shs[k]);
            check(req_of(5'(o)), result, model(5'(o), vals[i], vals[j], imms[k], shs[k]));
          end

    // R10 flags on every operand pair, under several codes
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 32; o += 7) begin
          apply(5'(o), vals[i], vals[j], 16'h8000, 5'd3);
          check("R10", {26'h0, cond}, {26'h0, flags(vals[i], vals[j])});
        end

    // every shift amount; rs carries junk above bit 4, shamt differs for variable forms
    for (int s = 0; s < 32; s++)
      for (int j = 0; j < 12; j++) begin
        apply(5'd8, 32'hdead_beef, vals[j], 16'h5a5a, 5'(s));
        check("R7", result, vals[j] << s);
        apply(5'd9, 32'hdead_beef, vals[j], 16'h5a5a, 5'(s));
        check("R9", result, vals[j] >> s);
        apply(5'd10, 32'hdead_beef, vals[j], 16'h5a5a, 5'(s));
        check("R9", result, 32'($signed(vals[j]) >>> s));
        apply(5'd11, {27'h5a5a5a5, 5'(s)}, vals[j], 16'hffff, 5'(31 - s));
        check("R8", result, vals[j] << s);
        apply(5'd12, {27'h7ffffff, 5'(s)}, vals[j], 16'hffff, 5'(31 - s));
        check("R8", result, vals[j] >> s);
        apply(5'd13, {27'h1234567, 5'(s)}, vals[j], 16'hffff, 5'(31 - s));
        check("R8", result, 32'($signed(vals[j]) >>> s));
      end

    // R12: register-operand codes ignore imm, and shamt where unused
    for (int o = 0; o < 14; o++)
      for (int k = 0; k < 6; k++) begin
        apply(5'(o), 32'h8000_0011, 32'hc001_d00d, imms[k], (o >= 8 && o <= 10) ? 5'd4 : shs[k]);
        check("R12", result, model(5'(o), 32'h8000_0011, 32'hc001_d00d, 16'h0,
                                   (o >= 8 && o <= 10) ? 5'd4 : 5'd0));
      end
    for (int o = 14; o < 21; o++)
      for (int k = 0; k < 6; k++) begin
        apply(5'(o), 32'h7fff_8000, 32'h1, 16'h8001, shs[k]);
        check("R12", result, model(5'(o), 32'h7fff_8000, 32'h1, 16'h8001, 5'd0));
      end

    // targeted boundaries
    apply(5'd0, 32'hffffffff, 32'h1, 16'h0, 5'd0);
    check("R1", result, 32'h0);
    apply(5'd14, 32'h100, 32'h0, 16'hfffc, 5'd0);
    check("R1", result, 32'hfc);
    apply(5'd16, 32'h7fffffff, 32'h0, 16'h8000, 5'd0);
    check("R3", result, 32'h1);
    apply(5'd15, 32'h7fffffff, 32'h0, 16'h8000, 5'd0);
    check("R2", result, 32'h0);
    apply(5'd17, 32'hffffffff, 32'h0, 16'h8000, 5'd0);
    check("R5", result, 32'h8000);
    apply(5'd20, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd31);
    check("R6", result, 32'habcd0000);
    apply(5'd25, 32'hffffffff, 32'hffffffff, 16'hffff, 5'd31);
    check("R11", result, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule